// File: doc/BRIEF.md
# SPI Host Control and Slave Dispatch

This block is the processor-facing side of an SPI host. A small register port exposes two addresses: a 16-bit control word and a byte-wide data port. The control word enables the host, picks which slave the data port talks to, sets whether chip select stays asserted after the byte, asks for an interrupt per transfer, and carries a request for 16-bit transfers that this block does not support.

A write to the data port while the host is enabled is a transfer. It is forwarded one cycle later as a single-cycle byte strobe to the slave, together with the current chip-select hold flag. This happens only when the device field selects the one attached slave. If interrupts are enabled, the interrupt line pulses in the same cycle, whichever device is selected. A read of the data port returns the byte the attached slave presents, or zero when the host is disabled or another device is selected. Shifting of bits on the wire and transfer latency belong to the slave side and are not modelled here.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, and `dev_wr`, `irq` and `wide_req` are low.
- R2: A control write (`bus_addr`=0) stores only the bits of `bus_wdata` under mask 0xCF03. A read at `bus_addr`=0 returns the stored value from the cycle after the write.
- R3: While control bit 15 (enable) is 0, a data write (`bus_addr`=1) produces no `dev_wr` and no `irq` pulse. A data read in that state returns 0.
- R4: With enable set, a data write with control bits 9:8 equal to 1 pulses `dev_wr` for one cycle, in the cycle after the write, with `dev_wdata` equal to `bus_wdata[7:0]`. With any other value in bits 9:8, no `dev_wr` pulse occurs and data reads return 0.
- R5: Each forwarded byte carries `dev_hold` equal to control bit 11 as it stood when the data write was accepted.
- R6: With enable and control bit 14 set, every data write pulses `irq` in the following cycle for any device value. With bit 14 clear, `irq` stays low.
- R7: `wide_req` follows control bit 10. The transfer stays 8 bits wide whatever its value.
- R8: With enable set and bits 9:8 equal to 1, a data read returns `{8'h00, dev_rdata}`.
- R9: Data writes on consecutive cycles give one forward or interrupt pulse per write, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 selects the data port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| dev_wr | output | 1 | Byte strobe to the attached slave |
| dev_wdata | output | 8 | Byte sent to the slave |
| dev_hold | output | 1 | Keep chip select asserted after this byte |
| dev_rdata | input | 8 | Byte returned by the slave |
| irq | output | 1 | Transfer-done interrupt pulse |
| wide_req | output | 1 | Unsupported 16-bit mode requested |

## Verification
The assertions assume that at most one register write happens per cycle and that `bus_addr` selects the target of that write. They also assume that `dev_rdata` is only meaningful while the attached slave is routed. The stimulus drives writes on falling edges and leaves the bus idle between most operations. One test issues back-to-back data writes to cover the pipelined case, and `dev_rdata` is held at a fixed byte during reads.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hCF03;
  localparam int B_EN    = 15;
  localparam int B_IRQEN = 14;
  localparam int B_HOLD  = 11;
  localparam int B_WIDE  = 10;
  localparam int B_DEVLO = 8;
  localparam int DEV_W   = 2;
  localparam logic [DEV_W-1:0] DEV_ATTACHED = 2'd1;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_DATA = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // R2: the stored word reflects the masked write
  p_store_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == ($past(wdata) & CTRL_MASK));

  // R2: without a write, the word holds
  p_store_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/spi_xfer_dispatch.sv
module spi_xfer_dispatch
  import spi_host_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              en,
  input  logic              irq_en,
  input  logic              hold,
  input  logic [DEV_W-1:0]  dev_sel,
  output logic              dev_wr,
  output logic [BYTE_W-1:0] dev_wdata,
  output logic              dev_hold,
  output logic              irq
);
  logic accept, fwd;
  logic wr_d, irq_d;

  always_comb begin
    accept = data_wr & en;
    fwd    = accept & (dev_sel == DEV_ATTACHED);
    wr_d   = fwd;
    irq_d  = accept & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_wr <= 1'b0;
      irq    <= 1'b0;
    end else begin
      dev_wr <= wr_d;
      irq    <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_wdata <= '0;
      dev_hold  <= 1'b0;
    end else if (fwd) begin
      dev_wdata <= wbyte;
      dev_hold  <= hold;
    end
  end

  // R3: a disabled host forwards nothing and raises nothing
  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !en) |=> (!dev_wr && !irq));

  // R4: an unrouted device gets no strobe
  p_no_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en && dev_sel != DEV_ATTACHED) |=> !dev_wr);

  // R4: a routed write appears next cycle with its byte
  p_route_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en && dev_sel == DEV_ATTACHED) |=> (dev_wr && dev_wdata == $past(wbyte)));

  // R5: hold flag travels with the byte
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> dev_hold == $past(hold));

  // R6: interrupt follows an accepted write with irq enabled
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en && irq_en) |=> irq);

  // R6: no interrupt without an accepted write
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && en && irq_en) |=> !irq);
endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
  import spi_host_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              addr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              en,
  input  logic [DEV_W-1:0]  dev_sel,
  input  logic [BYTE_W-1:0] dev_rdata,
  output logic [CTRL_W-1:0] rdata
);
  localparam int PAD_W = CTRL_W - BYTE_W;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata = ctrl;
    end else if (en && dev_sel == DEV_ATTACHED) begin
      rdata = {{PAD_W{1'b0}}, dev_rdata};
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic              dev_wr,
  output logic [BYTE_W-1:0] dev_wdata,
  output logic              dev_hold,
  input  logic [BYTE_W-1:0] dev_rdata,
  output logic              irq,
  output logic              wide_req
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr, data_wr;
  logic              en;
  logic [DEV_W-1:0]  dev_sel;

  always_comb begin
    ctrl_wr  = bus_wr & (bus_addr == ADDR_CTRL);
    data_wr  = bus_wr & (bus_addr == ADDR_DATA);
    en       = ctrl_q[B_EN];
    dev_sel  = ctrl_q[B_DEVLO +: DEV_W];
    wide_req = ctrl_q[B_WIDE];
  end

  spi_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  spi_xfer_dispatch #(.BYTE_W(BYTE_W)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .wbyte     (bus_wdata[BYTE_W-1:0]),
    .en        (en),
    .irq_en    (ctrl_q[B_IRQEN]),
    .hold      (ctrl_q[B_HOLD]),
    .dev_sel   (dev_sel),
    .dev_wr    (dev_wr),
    .dev_wdata (dev_wdata),
    .dev_hold  (dev_hold),
    .irq       (irq)
  );

  spi_rd_mux #(.BYTE_W(BYTE_W)) u_rmux (
    .addr      (bus_addr),
    .ctrl      (ctrl_q),
    .en        (en),
    .dev_sel   (dev_sel),
    .dev_rdata (dev_rdata),
    .rdata     (bus_rdata)
  );

  // R3: disabled data reads are zero
  p_rd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_DATA && !ctrl_q[B_EN]) |-> bus_rdata == '0);

  // R7: a wide request never widens the forwarded strobe data
  p_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wide_req && en && dev_sel == DEV_ATTACHED) |=> dev_wdata == $past(bus_wdata[BYTE_W-1:0]));
endmodule

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dev_wr;
  logic [7:0]  dev_wdata;
  logic        dev_hold;
  logic [7:0]  dev_rdata = 8'h3C;
  logic        irq;
  logic        wide_req;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  logic [15:0] shadow = '0;

  typedef struct {
    int         due;
    logic       fwd;
    logic [7:0] data;
    logic       hold;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  spi_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_hold(dev_hold), .dev_rdata(dev_rdata),
    .irq(irq), .wide_req(wide_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (dev_wr !== e.fwd || irq !== e.irq ||
            (e.fwd && (dev_wdata !== e.data || dev_hold !== e.hold))) begin
          errors++;
          $display("FAIL %s: wr=%b data=%h hold=%b irq=%b expected wr=%b data=%h hold=%b irq=%b",
                   e.tag, dev_wr, dev_wdata, dev_hold, irq, e.fwd, e.data, e.hold, e.irq);
        end
      end else if (dev_wr || irq) begin
        vectors++;
        errors++;
        $display("FAIL R9: unexpected pulse wr=%b irq=%b expected 0 0", dev_wr, irq);
      end
    end
  end

  task automatic ctrl_write(input logic [15:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
    shadow = v & 16'hCF03;
  endtask

  task automatic data_write(input logic [7:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = {8'hEE, b};
    e.due  = cyc + 1;
    e.fwd  = shadow[15] && shadow[9:8] == 2'd1;
    e.data = b;
    e.hold = shadow[11];
    e.irq  = shadow[15] && shadow[14];
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check_read(input logic a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, bus_rdata, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_read(1'b0, 16'h0000, "R1");
    check_bit(dev_wr, 1'b0, "R1");
    check_bit(irq, 1'b0, "R1");
    check_bit(wide_req, 1'b0, "R1");

    // R2 mask
    ctrl_write(16'hFFFF); idle();
    check_read(1'b0, 16'hCF03, "R2");
    check_bit(wide_req, 1'b1, "R7");
    ctrl_write(16'h30FC); idle();
    check_read(1'b0, 16'h0000, "R2");

    // R3 disabled
    ctrl_write(16'h4900); idle();
    data_write(8'h5A, "R3"); idle();
    check_read(1'b1, 16'h0000, "R3");

    // R4 / R8 routed, no irq
    ctrl_write(16'h8100); idle();
    data_write(8'hA5, "R4"); idle();
    check_read(1'b1, 16'h003C, "R8");

    // R5 / R6 hold and irq
    ctrl_write(16'hC900); idle();
    data_write(8'h11, "R5"); idle();

    // R4 / R6 other device: irq but no forward
    ctrl_write(16'hC200); idle();
    data_write(8'h22, "R6"); idle();
    check_read(1'b1, 16'h0000, "R4");
    ctrl_write(16'hC300); idle();
    data_write(8'h23, "R4"); idle();

    // R7 wide request still 8-bit forward
    ctrl_write(16'h8500); idle();
    check_bit(wide_req, 1'b1, "R7");
    data_write(8'h33, "R7"); idle();

    // R9 back-to-back writes
    ctrl_write(16'hC900); idle();
    data_write(8'h44, "R9");
    data_write(8'h55, "R9");
    data_write(8'h66, "R9");
    idle();
    ctrl_write(16'h8000); idle();
    data_write(8'h77, "R4"); idle();

    repeat (4) @(negedge clk);
    check_bit(sb.size() == 0, 1'b1, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule